// File: doc/BRIEF.md
# JTAG Stable-State Path Sequencer

This block sits on the master side of a JTAG test port and moves the target's TAP controller from one resting state to another. A caller names the resting state it wants. The sequencer compares that state with the TAP state it is tracking. It then emits a TMS bit for each test clock step and follows a fixed default route through the sixteen-state TAP graph. With every bit it gives a one-cycle strobe that tells the pin driver to produce one TCK edge. Only four states count as resting states: Test-Logic-Reset, Run-Test/Idle, Pause-DR and Pause-IR. A request for any other state is refused and raises an error pulse.

The routes are fixed. A pause state never counts as already reached, so asking for the pause state the TAP is already in makes a full loop back to it. The loop passes through Update of the current branch and ends by capturing the requested branch. Reset-to-reset and idle-to-idle requests finish with no steps. The request port is a valid/ready pair. `req_ready` is low for the whole walk. The caller holds `req_valid` and `req_target` until `req_ready` is also high, and a request is taken in the cycle where both are high. Any request offered during a walk waits for that walk to finish and does not alter it. The step rate comes from a clock divider set by `STEP_DIV`.

Top module: `jtag_walk_seq`

## Requirements
- R1: After a synchronous reset, `tap_state` reads 0 (Test-Logic-Reset), `busy`, `done`, `err`, `tck_pulse` and `tms` are 0, and `req_ready` is 1.
- R2: A request whose target code is not one of 0, 1, 6 or 13 makes `err` high for exactly the next cycle. It produces no strobe, leaves `tap_state` unchanged and never sets `busy`.
- R3: A request from reset to reset (code 0) or from idle to idle (code 1) produces no strobe. `done` pulses in the cycle after the handshake.
- R4: During a walk, `tck_pulse` comes first `STEP_DIV` cycles after the handshake cycle and then every `STEP_DIV` cycles. It is never high outside a walk.
- R5: The TMS bits, in order, are 0 for reset to idle, 1,1,1 for idle to reset, 0,1,0,1,0 for reset to Pause-DR, 0,1,1,0,1,0 for reset to Pause-IR, 1,0,1,0 for idle to Pause-DR and 1,1,0,1,0 for idle to Pause-IR.
- R6: From either pause state the TMS bits are 1,1,0 to reach idle and 1,1,1,1,1 to reach reset.
- R7: A request for the pause state already held is a round trip: 1,1,1,0,1,0 for Pause-DR and 1,1,1,1,0,1,0 for Pause-IR.
- R8: Pause-DR to Pause-IR uses 1,1,1,1,0,1,0, and Pause-IR to Pause-DR uses 1,1,1,0,1,0.
- R9: `tap_state` changes only in the cycle after a strobe, and the new state follows the standard TAP transition for the TMS bit of that strobe. Codes: 0 reset, 1 idle, 2 to 8 are Select, Capture, Shift, Exit1, Pause, Exit2 and Update of the DR branch, and 9 to 15 are the same states of the IR branch.
- R10: `done` is high for exactly one cycle, the cycle after the final strobe. In that cycle `tap_state` equals the target, `busy` is 0 and `req_ready` is 1.
- R11: `req_ready` is low while `busy` is high. A request offered during a walk does not change the TMS sequence or the final state.
- R12: After `FORCE_ONES` consecutive strobes with TMS at 1, `tap_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Move request offered |
| req_ready | output | 1 | Sequencer can accept a request |
| req_target | input | 4 | Code of the requested resting state |
| tck_pulse | output | 1 | One-cycle strobe: issue one TCK step with `tms` |
| tms | output | 1 | TMS value for the current step |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Pulse: target reached |
| err | output | 1 | Pulse: request rejected |
| tap_state | output | 4 | Tracked TAP state code |

## Verification
The bench builds the block with `STEP_DIV` at 3 and `FORCE_ONES` at 5. With these values a seven-step route finishes in about twenty cycles, so every start and target pair among the resting states fits into one short run, along with the spacing of the strobes and the rule that five ones reach reset. The walks from a pause state to reset send exactly five ones in a row, so the forced reset falls at the last strobe of those walks.

// File: rtl/jtag_walk_pkg.sv
package jtag_walk_pkg;

  localparam int TAP_W = 4;

  typedef enum logic [TAP_W-1:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SHF_DR = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SHF_IR = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_st_e;

  // Resting states: the only legal endpoints of a walk
  function automatic logic is_rest(input tap_st_e s);
    return (s == ST_RESET) || (s == ST_IDLE) ||
           (s == ST_PAU_DR) || (s == ST_PAU_IR);
  endfunction

  // Standard TAP transition graph
  function automatic tap_st_e tap_step(input tap_st_e s, input logic m);
    tap_st_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      default:   n = m ? ST_SEL_DR : ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jtag_step_timer.sv
module jtag_step_timer #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic strobe
);

  generate
    if (STEP_DIV <= 1) begin : g_every
      assign strobe = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(STEP_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign strobe = run && (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/jtag_tap_tracker.sv
module jtag_tap_tracker
  import jtag_walk_pkg::*;
#(
  parameter int FORCE_ONES = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    step,
  input  logic    tms,
  output tap_st_e state
);

  localparam int OW = $clog2(FORCE_ONES + 1);
  localparam logic [OW-1:0] ONES_LAST = OW'(FORCE_ONES - 1);

  logic [OW-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RESET;
      ones  <= '0;
    end else if (step) begin
      if (!tms) begin
        ones  <= '0;
        state <= tap_step(state, 1'b0);
      end else if (ones == ONES_LAST) begin
        // a run of ones always lands in reset, whatever the start
        state <= ST_RESET;
      end else begin
        ones  <= ones + 1'b1;
        state <= tap_step(state, 1'b1);
      end
    end
  end

endmodule

// File: rtl/jtag_hop_planner.sv
module jtag_hop_planner
  import jtag_walk_pkg::*;
(
  input  tap_st_e cur,
  input  tap_st_e tgt,
  output logic    tms,
  output logic    arrive
);

  always_comb begin
    case (cur)
      ST_RESET:             tms = 1'b0;
      ST_IDLE:              tms = 1'b1;
      ST_SEL_DR:            tms = (tgt != ST_PAU_DR);
      ST_SEL_IR:            tms = (tgt != ST_PAU_IR);
      ST_CAP_DR, ST_CAP_IR: tms = 1'b1;
      ST_EX1_DR, ST_EX1_IR: tms = 1'b0;
      ST_PAU_DR, ST_PAU_IR: tms = 1'b1;
      ST_EX2_DR, ST_EX2_IR: tms = 1'b1;
      ST_UPD_DR, ST_UPD_IR: tms = (tgt != ST_IDLE);
      default:              tms = 1'b1;
    endcase
  end

  assign arrive = (tap_step(cur, tms) == tgt);

endmodule

// File: rtl/jtag_walk_seq.sv
module jtag_walk_seq
  import jtag_walk_pkg::*;
#(
  parameter int STEP_DIV   = 4,
  parameter int FORCE_ONES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAP_W-1:0] req_target,
  output logic             tck_pulse,
  output logic             tms,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [TAP_W-1:0] tap_state
);

  tap_st_e cur;
  tap_st_e tgt_q;
  tap_st_e req_st;
  logic    busy_q, done_q, err_q;
  logic    strobe, plan_tms, arrive;
  logic    accept, tgt_ok, no_move;

  assign req_st  = tap_st_e'(req_target);
  assign accept  = req_valid && !busy_q;
  assign tgt_ok  = is_rest(req_st) && is_rest(cur);
  assign no_move = (req_st == cur) && ((cur == ST_RESET) || (cur == ST_IDLE));

  jtag_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (busy_q),
    .strobe (strobe)
  );

  jtag_hop_planner u_plan (
    .cur    (cur),
    .tgt    (tgt_q),
    .tms    (plan_tms),
    .arrive (arrive)
  );

  jtag_tap_tracker #(.FORCE_ONES(FORCE_ONES)) u_track (
    .clk   (clk),
    .rst   (rst),
    .step  (strobe),
    .tms   (plan_tms),
    .state (cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tgt_q  <= ST_RESET;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (!tgt_ok) begin
          err_q <= 1'b1;
        end else if (no_move) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          tgt_q  <= req_st;
        end
      end else if (busy_q && strobe && arrive) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign tck_pulse = strobe;
  assign tms       = busy_q & plan_tms;
  assign tap_state = cur;

endmodule

// File: rtl/jtag_walk_seq_chk.sv
module jtag_walk_seq_chk #(
  parameter int FORCE_ONES = 5
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_target,
  input logic       tck_pulse,
  input logic       tms,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [3:0] tap_state
);

  logic [3:0] want_q;
  logic [3:0] ones_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q   <= 4'd0;
      ones_run <= 4'd0;
    end else begin
      if (req_valid && req_ready) want_q <= req_target;
      if (tck_pulse) ones_run <= tms ? ((ones_run == 4'd15) ? ones_run : ones_run + 4'd1) : 4'd0;
    end
  end

  AST_REJECT_STILL: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(tap_state) && !busy)) else $error("reject moved state"); // R2

  AST_STROBE_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    tck_pulse |-> busy) else $error("strobe outside walk"); // R4

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$past(tck_pulse) |-> $stable(tap_state)) else $error("state moved without strobe"); // R9

  AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    done |-> (tap_state == want_q && !busy)) else $error("done off target"); // R10

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err})) else $error("done and err together"); // R10

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready) else $error("ready during walk"); // R11

  AST_ONES_RESET: assert property (@(posedge clk) disable iff (rst)
    (32'(ones_run) >= FORCE_ONES) |-> (tap_state == 4'd0)) else $error("ones run missed reset"); // R12

endmodule

bind jtag_walk_seq jtag_walk_seq_chk #(.FORCE_ONES(FORCE_ONES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_target (req_target),
  .tck_pulse  (tck_pulse),
  .tms        (tms),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .tap_state  (tap_state)
);

// File: tb/jtag_walk_seq_tb.sv
module jtag_walk_seq_tb;

  localparam int DIV   = 3;
  localparam int ONES  = 5;
  localparam logic [3:0] C_RST = 4'd0, C_IDL = 4'd1, C_PDR = 4'd6, C_PIR = 4'd13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [3:0] req_target = 4'd0;
  logic req_ready, tck_pulse, tms, busy, done, err;
  logic [3:0] tap_state;

  int checks = 0, errors = 0, cyc = 0;
  int hs_cyc = 0, last_pulse_cyc = 0;
  bit first_pending = 1'b0;
  bit finished = 1'b0;
  bit exp_q[$];
  string cur_tag = "R4";
  logic [3:0] model = 4'd0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  jtag_walk_seq #(.STEP_DIV(DIV), .FORCE_ONES(ONES)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .tck_pulse(tck_pulse), .tms(tms), .busy(busy),
    .done(done), .err(err), .tap_state(tap_state)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string route(input logic [3:0] s, input logic [3:0] e);
    case ({s, e})
      {C_RST, C_IDL}: return "0";
      {C_RST, C_PDR}: return "01010";
      {C_RST, C_PIR}: return "011010";
      {C_IDL, C_RST}: return "111";
      {C_IDL, C_PDR}: return "1010";
      {C_IDL, C_PIR}: return "11010";
      {C_PDR, C_RST}, {C_PIR, C_RST}: return "11111";
      {C_PDR, C_IDL}, {C_PIR, C_IDL}: return "110";
      {C_PDR, C_PDR}, {C_PIR, C_PDR}: return "111010";
      {C_PDR, C_PIR}, {C_PIR, C_PIR}: return "1111010";
      default: return "";
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s, input logic [3:0] e);
    bit s_pause = (s == C_PDR) || (s == C_PIR);
    bit e_pause = (e == C_PDR) || (e == C_PIR);
    if (!s_pause) return (s == e) ? "R3" : "R5";
    if (!e_pause) return "R6";
    return (s == e) ? "R7" : "R8";
  endfunction

  // Monitor: pops one expected bit per strobe
  always @(negedge clk) begin
    if (!rst && tck_pulse) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "strobe with no expected step", 1, 0);
      end else begin
        bit e_b;
        e_b = exp_q.pop_front();
        check(tms == e_b, cur_tag, "tms bit", int'(tms), int'(e_b));
      end
      if (first_pending)
        check(cyc - hs_cyc == DIV, "R4", "first strobe delay", cyc - hs_cyc, DIV);
      else
        check(cyc - last_pulse_cyc == DIV, "R4", "strobe spacing", cyc - last_pulse_cyc, DIV);
      first_pending = 1'b0;
      last_pulse_cyc = cyc;
    end
  end

  task automatic move(input logic [3:0] e, input bit poke);
    string p;
    string tg;
    int n;
    p  = route(model, e);
    tg = tag_of(model, e);
    cur_tag = tg;
    for (int i = 0; i < p.len(); i++) exp_q.push_back(p[i] == "1");
    @(negedge clk);
    req_valid = 1'b1;
    req_target = e;
    hs_cyc = cyc;
    first_pending = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke && p.len() > 2) begin
      check(busy && !req_ready, "R11", "ready low in walk", int'(req_ready), 0);
      req_valid = 1'b1;
      req_target = (e == C_RST) ? C_IDL : C_RST;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(done, tg, "done seen", int'(done), 1);
    check(exp_q.size() == 0, tg, "steps left", exp_q.size(), 0);
    check(tap_state == e, tg, "final state", int'(tap_state), int'(e));
    check(!busy && req_ready, "R10", "idle at done", int'(busy), 0);
    if (p.len() > 0)
      check(cyc - last_pulse_cyc == 1, "R10", "done after last strobe", cyc - last_pulse_cyc, 1);
    else
      check(cyc - hs_cyc == 1, "R3", "done after handshake", cyc - hs_cyc, 1);
    if (p == "11111")
      check(tap_state == C_RST, "R12", "five ones reach reset", int'(tap_state), 0);
    exp_q.delete();
    model = e;
    @(negedge clk);
    check(!done, "R10", "done single cycle", int'(done), 0);
  endtask

  task automatic reject(input logic [3:0] e);
    @(negedge clk);
    req_valid = 1'b1;
    req_target = e;
    @(negedge clk);
    req_valid = 1'b0;
    check(err, "R2", "err pulse", int'(err), 1);
    check(!busy && !done, "R2", "no walk on reject", int'(busy), 0);
    repeat (2 * DIV) @(negedge clk);
    check(!err, "R2", "err single cycle", int'(err), 0);
    check(tap_state == model, "R2", "state kept", int'(tap_state), int'(model));
  endtask

  initial begin
    logic [3:0] rest[4];
    rest = '{C_RST, C_IDL, C_PDR, C_PIR};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tap_state == 4'd0, "R1", "reset state", int'(tap_state), 0);
    check(!busy && req_ready, "R1", "idle after reset", int'(busy), 0);
    check(!tms && !tck_pulse, "R1", "quiet outputs", int'(tms), 0);
    check(!done && !err, "R1", "no pulses", int'(done), 0);
    reject(4'd4);
    foreach (rest[si]) begin
      foreach (rest[ei]) begin
        move(rest[si], 1'b0);
        move(rest[ei], (si + ei) % 2 == 1);
      end
    end
    reject(4'd15);
    move(C_PIR, 1'b0);
    reject(4'd2);
    move(C_RST, 1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WDOG", "watchdog expired", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule